// File: doc/BRIEF.md
# Pre-Encoded Signed-Digit Coefficient Multiplier

This block multiplies a run-time two's-complement operand by one of a fixed set of coefficients. The coefficients sit in an on-chip table that is filled at elaboration time, already recoded into a non-redundant radix-4 signed-digit form. Each coefficient therefore reaches the datapath as digits, and no recoding happens while the block runs. Every lower digit takes two stored bits. The most significant digit keeps three radix-4 Booth control bits. One coefficient word is DATA_W+1 bits wide.

A request is one operand plus a coefficient index, qualified by a valid strobe. The first pipeline stage registers the operand and the stored coefficient word. In the second stage, a small per-digit decoder turns each stored bit pair into magnitude and sign controls. Those controls select shifted, conditionally inverted copies of the operand. The copies, together with a row of correction carries, go through a carry-save reduction and then a prefix carry-lookahead adder, and the sum is registered. A parameter selects one of two digit variants. In the negative-leaning variant lower digits lie in {-2,-1,0,+1}. In the positive-leaning variant they lie in {-1,0,+1,+2}. The product is the same in both.

Top module: `nr4sdCoefMul`

## Requirements
- R1: An asynchronous active-low reset clears outValid and product to zero. A request that is still inside the pipeline when reset is asserted never produces an outValid pulse.
- R2: For every rising edge that samples inValid high, outValid is high for exactly one cycle, two rising edges later. A rising edge that samples inValid low produces outValid low two rising edges later.
- R3: The product is the full 2*DATA_W-bit two's-complement value of signed opA times the signed coefficient selected by coefAddr.
- R4: Table entry i holds: i=0 the most negative value (top bit only); i=1 the most positive value; i=2 zero; i=3 all ones (-1); i=4 one; i=5 ones in every even bit position (0x55 for 8 bits); i=6 ones in every odd bit position (0xAA); any other i holds (37*i+11) modulo 2^DATA_W, read as two's complement.
- R5: Stored word layout. For lower digit j, bits 2j+1 and 2j carry weights -2 and +1 in the negative variant, and +2 and -1 in the positive variant. Bits DATA_W, DATA_W-1 and DATA_W-2 hold the top digit's sign, times-two and times-one controls. For every digit, the decoded times-one and times-two controls are never both set, and sign is set only when one of them is set.
- R6: The positive-variant build gives a product bit-identical to the negative-variant build for every table entry and every operand.
- R7: A new request is accepted on every cycle. Back-to-back requests give their results on consecutive cycles, in order.
- R8: While no result is being delivered, product holds its last value and outValid stays low. Changes on opA and coefAddr with inValid low have no effect.
- R9: The corner products are exact. Most-negative times most-negative gives +2^(2*DATA_W-2). Most-negative times most-positive gives -2^(DATA_W-1)*(2^(DATA_W-1)-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe; opA and coefAddr are sampled when high |
| opA | input | DATA_W | Two's-complement run-time operand |
| coefAddr | input | $clog2(COEF_DEPTH) | Index of the stored coefficient |
| outValid | output | 1 | High for one cycle when product carries a new result |
| product | output | 2*DATA_W | Two's-complement product, held between results |

## Verification
Two events can fall on the same edge. One is the capture of a new request into the first stage. The other is the delivery of the previous request's product into the output register. If the stages share state wrongly, a result picks up the wrong operand or the wrong coefficient word. The bench provokes this by streaming a table of requests with inValid held high on consecutive cycles. Each output cycle is compared against the product of the request issued two cycles earlier, and both digit variants must agree bit for bit. A reset asserted while a request is in flight checks that the capture path and the delivery path are both cleared together.

// File: rtl/nr4sdPkg.sv
package nr4sdPkg;

  // Digit variant held in the coefficient table
  typedef enum logic {
    SD_MINUS = 1'b0,   // lower digits in {-2,-1,0,+1}
    SD_PLUS  = 1'b1    // lower digits in {-1,0,+1,+2}
  } sdForm_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureIn;   // load operand and coefficient word
    logic captureOut;  // load the finished sum into product
  } mulStrobes_t;

  // Per-digit partial-product selection
  typedef struct packed {
    logic sign;
    logic two;
    logic one;
  } digitCtl_t;

endpackage

// File: rtl/nr4sdPairDecode.sv
module nr4sdPairDecode #(
  parameter nr4sdPkg::sdForm_e FORM = nr4sdPkg::SD_MINUS
) (
  input  logic [1:0]           pair,
  output nr4sdPkg::digitCtl_t  ctl
);

  // pair[1] is the odd-position bit, pair[0] the even-position bit
  generate
    if (FORM == nr4sdPkg::SD_MINUS) begin : gMinus
      // value = -2*pair[1] + pair[0]
      assign ctl.one  = pair[0];
      assign ctl.two  = pair[1] & ~pair[0];
      assign ctl.sign = pair[1];
    end else begin : gPlus
      // value = +2*pair[1] - pair[0]
      assign ctl.one  = pair[0];
      assign ctl.two  = pair[1] & ~pair[0];
      assign ctl.sign = ~pair[1] & pair[0];
    end
  endgenerate

endmodule

// File: rtl/nr4sdClaAdder.sv
module nr4sdClaAdder #(
  parameter int W = 16
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  output logic [W-1:0] sum
);

  localparam int CW  = W - 1;            // carries needed into bits 1..W-1
  localparam int LVL = (CW > 1) ? $clog2(CW) : 1;

  logic [CW-1:0] groupGen;

  // Kogge-Stone prefix over generate/propagate
  always_comb begin
    logic [CW-1:0] gk, pk, gn, pn;
    gk = addA[CW-1:0] & addB[CW-1:0];
    pk = addA[CW-1:0] ^ addB[CW-1:0];
    for (int l = 0; l < LVL; l++) begin
      for (int i = 0; i < CW; i++) begin
        if (i >= (1 << l)) begin
          gn[i] = gk[i] | (pk[i] & gk[i - (1 << l)]);
          pn[i] = pk[i] & pk[i - (1 << l)];
        end else begin
          gn[i] = gk[i];
          pn[i] = pk[i];
        end
      end
      gk = gn;
      pk = pn;
    end
    groupGen = gk;
  end

  assign sum = (addA ^ addB) ^ {groupGen, 1'b0};

endmodule

// File: rtl/nr4sdCtrl.sv
module nr4sdCtrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  output nr4sdPkg::mulStrobes_t  strobes,
  output logic                   outValid
);

  logic stage1Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  assign strobes.captureIn  = inValid;
  assign strobes.captureOut = stage1Valid;

  // R2: an accepted request produces a result two edges later
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##2 outValid);

  // R2: no result without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> ##2 !outValid);

endmodule

// File: rtl/nr4sdDatapath.sv
module nr4sdDatapath #(
  parameter int                DATA_W     = 8,
  parameter int                COEF_DEPTH = 16,
  parameter nr4sdPkg::sdForm_e FORM       = nr4sdPkg::SD_MINUS,
  localparam int               ADDR_W     = $clog2(COEF_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  nr4sdPkg::mulStrobes_t  strobes,
  input  logic [DATA_W-1:0]      opA,
  input  logic [ADDR_W-1:0]      coefAddr,
  output logic [2*DATA_W-1:0]    product
);

  localparam int N      = DATA_W;
  localparam int K      = N / 2;       // radix-4 digits per coefficient
  localparam int W      = 2 * N;       // product width
  localparam int WORD_W = N + 1;       // stored bits per coefficient

  // Coefficient set, R4
  function automatic logic [N-1:0] coefPattern(input int idx);
    logic [N-1:0] r;
    r = N'(idx * 37 + 11);
    case (idx)
      0: r = {1'b1, {(N-1){1'b0}}};
      1: r = {1'b0, {(N-1){1'b1}}};
      2: r = '0;
      3: r = '1;
      4: r = N'(1);
      5: for (int b = 0; b < N; b++) r[b] = (b % 2 == 0);
      6: for (int b = 0; b < N; b++) r[b] = (b % 2 == 1);
      default: ;
    endcase
    return r;
  endfunction

  // Elaboration-time recoding into the stored word, R5
  function automatic logic [WORD_W-1:0] encodeCoef(input logic [N-1:0] b);
    logic [WORD_W-1:0] w;
    int c, v, t;
    w = '0;
    c = 0;
    for (int j = 0; j < K - 1; j++) begin
      v = 2 * int'(b[2*j+1]) + int'(b[2*j]) + c;
      if (FORM == nr4sdPkg::SD_MINUS) begin
        w[2*j+1 -: 2] = 2'(v % 4);
        c = (v >= 2) ? 1 : 0;
      end else begin
        case (v)
          1:       w[2*j+1 -: 2] = 2'b11;
          2:       w[2*j+1 -: 2] = 2'b10;
          3:       w[2*j+1 -: 2] = 2'b01;
          default: w[2*j+1 -: 2] = 2'b00;
        endcase
        c = (v >= 3) ? 1 : 0;
      end
    end
    t = int'(b[N-2]) - 2 * int'(b[N-1]) + c;
    w[N]   = (t < 0);
    w[N-1] = (t == 2) || (t == -2);
    w[N-2] = (t == 1) || (t == -1);
    return w;
  endfunction

  // Pre-encoded coefficient table
  logic [WORD_W-1:0] romWords [COEF_DEPTH];
  for (genvar i = 0; i < COEF_DEPTH; i++) begin : gRom
    assign romWords[i] = encodeCoef(coefPattern(i));
  end

  // Stage 1 registers
  logic [N-1:0]      aReg;
  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg    <= '0;
      wordReg <= '0;
    end else if (strobes.captureIn) begin
      aReg    <= opA;
      wordReg <= romWords[coefAddr];
    end
  end

  // Digit controls
  nr4sdPkg::digitCtl_t digitCtl [K];

  for (genvar j = 0; j < K; j++) begin : gDigit
    if (j == K - 1) begin : gTop
      assign digitCtl[j] = wordReg[N:N-2];
    end else begin : gLow
      nr4sdPairDecode #(.FORM(FORM)) uDec (
        .pair (wordReg[2*j+1:2*j]),
        .ctl  (digitCtl[j])
      );
    end

    // R5: a digit never selects both magnitudes
    a_r5_digit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({digitCtl[j].one, digitCtl[j].two}));

    // R5: a negative digit always has a magnitude
    a_r5_sign_has_mag: assert property (@(posedge clk) disable iff (!rst_n)
      digitCtl[j].sign |-> (digitCtl[j].one | digitCtl[j].two));
  end

  // Partial products and correction row
  logic [W-1:0] ppRow [K];
  logic [W-1:0] cinRow;
  logic [W-1:0] aExt;

  assign aExt = {{(W-N){aReg[N-1]}}, aReg};

  always_comb begin
    logic [W-1:0] mag;
    cinRow = '0;
    for (int j = 0; j < K; j++) begin
      if (digitCtl[j].two)      mag = aExt << 1;
      else if (digitCtl[j].one) mag = aExt;
      else                      mag = '0;
      ppRow[j]    = (mag ^ {W{digitCtl[j].sign}}) << (2 * j);
      cinRow[2*j] = digitCtl[j].sign;
    end
  end

  // Carry-save reduction
  logic [W-1:0] csSum, csCarry;

  always_comb begin
    logic [W-1:0] s, c, r;
    s = cinRow;
    c = '0;
    for (int j = 0; j < K; j++) begin
      r = ppRow[j];
      {s, c} = {s ^ c ^ r, ((s & c) | (s & r) | (c & r)) << 1};
    end
    csSum   = s;
    csCarry = c;
  end

  logic [W-1:0] finalSum;

  nr4sdClaAdder #(.W(W)) uCla (
    .addA (csSum),
    .addB (csCarry),
    .sum  (finalSum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  product <= '0;
    else if (strobes.captureOut) product <= finalSum;
  end

endmodule

// File: rtl/nr4sdCoefMul.sv
module nr4sdCoefMul #(
  parameter int                DATA_W     = 8,
  parameter int                COEF_DEPTH = 16,
  parameter nr4sdPkg::sdForm_e FORM       = nr4sdPkg::SD_MINUS,
  localparam int               ADDR_W     = $clog2(COEF_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic [DATA_W-1:0]     opA,
  input  logic [ADDR_W-1:0]     coefAddr,
  output logic                  outValid,
  output logic [2*DATA_W-1:0]   product
);

  nr4sdPkg::mulStrobes_t strobes;

  nr4sdCtrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  nr4sdDatapath #(
    .DATA_W     (DATA_W),
    .COEF_DEPTH (COEF_DEPTH),
    .FORM       (FORM)
  ) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opA      (opA),
    .coefAddr (coefAddr),
    .product  (product)
  );

  // R8: the product only moves on a delivery cycle
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(product));

endmodule

// File: tb/nr4sdCoefMul_test.sv
`timescale 1ns/1ps
module nr4sdCoefMul_test;

  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int PW    = 2 * DW;
  localparam int NV    = 20;

  // Stream table: coefficient index and operand per request
  localparam int VADDR [NV] = '{0, 0, 1, 1, 2, 3, 3, 4, 5, 6,
                                7, 8, 9, 10, 11, 12, 13, 14, 15, 5};
  localparam int VA    [NV] = '{-128, 127, -128, 127, -77, -1, -128, -128, 85, -86,
                                3, -2, 100, -100, 55, -55, 1, -64, 64, -1};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           inValid = 1'b0;
  logic [DW-1:0]  opA = '0;
  logic [AW-1:0]  coefAddr = '0;
  logic           outValid, outValidP;
  logic [PW-1:0]  product, productP;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;   // 125 MHz

  nr4sdCoefMul #(.DATA_W(DW), .COEF_DEPTH(DEPTH), .FORM(nr4sdPkg::SD_MINUS)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .coefAddr(coefAddr),
    .outValid(outValid), .product(product));

  nr4sdCoefMul #(.DATA_W(DW), .COEF_DEPTH(DEPTH), .FORM(nr4sdPkg::SD_PLUS)) uutPlus (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .coefAddr(coefAddr),
    .outValid(outValidP), .product(productP));

  // Coefficient value per R4
  function automatic longint coefOf(input int idx);
    longint v;
    case (idx)
      0: v = -(longint'(1) << (DW - 1));
      1: v = (longint'(1) << (DW - 1)) - 1;
      2: v = 0;
      3: v = -1;
      4: v = 1;
      5: begin v = 0; for (int b = 0; b < DW; b += 2) v += longint'(1) << b; end
      6: begin v = 0; for (int b = 1; b < DW; b += 2) v += longint'(1) << b; end
      default: v = (idx * 37 + 11) % (1 << DW);
    endcase
    if (v >= (longint'(1) << (DW - 1))) v -= longint'(1) << DW;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sProd(input logic [PW-1:0] p);
    return longint'($signed(p));
  endfunction

  // Single request, result checked two edges later
  task automatic runOne(input int addr, input int a, input string tag);
    longint exp;
    exp = coefOf(addr) * longint'(a);
    @(negedge clk);
    inValid = 1'b1; coefAddr = AW'(addr); opA = DW'(a);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({tag, " R3 product"}, sProd(product), exp);
    check({tag, " R6 plus-form product"}, sProd(productP), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    longint lastExp;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outValid", longint'(outValid), 0);
    check("R1 reset product", sProd(product), 0);
    rst_n = 1'b1;

    // R7/R2/R3/R6: back-to-back stream
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        longint exp;
        exp = coefOf(VADDR[i-2]) * longint'(VA[i-2]);
        check("R7 stream outValid", longint'(outValid), 1);
        check("R7 stream product", sProd(product), exp);
        check("R6 stream plus-form product", sProd(productP), exp);
      end
      if (i < NV) begin
        inValid = 1'b1; coefAddr = AW'(VADDR[i]); opA = DW'(VA[i]);
      end else begin
        inValid = 1'b0;
      end
    end
    lastExp = coefOf(VADDR[NV-1]) * longint'(VA[NV-1]);

    // R8: idle inputs move, outputs hold
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opA = DW'(k * 29 + 3); coefAddr = AW'(k + 7);
      check("R8 idle outValid", longint'(outValid), 0);
      check("R8 idle product held", sProd(product), lastExp);
    end

    // R2/R9: single pulse, corner product
    @(negedge clk);
    inValid = 1'b1; coefAddr = AW'(0); opA = DW'(-128);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 no early outValid", longint'(outValid), 0);
    @(negedge clk);
    check("R2 outValid on second edge", longint'(outValid), 1);
    check("R9 min*min", sProd(product), longint'(1) << (2 * DW - 2));
    @(negedge clk);
    check("R2 outValid single cycle", longint'(outValid), 0);
    check("R8 product held after pulse", sProd(product), longint'(1) << (2 * DW - 2));

    runOne(1, -128, "R9 min*max");
    check("R9 min*max value", sProd(product), -128 * 127);

    // R3/R4/R6: every entry against several operands
    for (int addr = 0; addr < DEPTH; addr++) begin
      runOne(addr, -128, "R4 sweep");
      runOne(addr, 127, "R4 sweep");
      runOne(addr, -1, "R4 sweep");
      runOne(addr, 0, "R4 sweep");
      runOne(addr, 85, "R4 sweep");
      runOne(addr, -43, "R4 sweep");
    end

    // R1: reset while a request is in flight
    @(negedge clk);
    inValid = 1'b1; coefAddr = AW'(1); opA = DW'(99);
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset outValid", longint'(outValid), 0);
    check("R1 mid-run reset product", sProd(product), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flushed request outValid", longint'(outValid), 0);
    @(negedge clk);
    check("R1 flushed request outValid later", longint'(outValid), 0);
    check("R1 product stays cleared", sProd(product), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule